// File: doc/BRIEF.md
# Board Reset and CPU Start Sequencer

This block drives the reset lines of an adapter board from three commands and a slow time base. A reset command produces two separate, ordered pulses: first on the host bridge soft-reset line, then on the line that makes the bridge reload its configuration EEPROM. Each pulse and each gap after it lasts a set number of ticks. The sequence ends by writing an all-zero CPU control word, which holds the embedded CPU fully in reset. A start command releases the CPU in two stages. First only the cold-reset enable is set. After a short wait the warm-reset enable joins it, and a longer settling wait follows before completion is reported.

Time is counted in ticks of an external one-cycle strobe, typically one per millisecond. A wait counts only the ticks that arrive after the cycle in which its control write happened. While a sequence runs, `busy` is high and every new command is dropped. A one-cycle `done` pulse marks the end of a reset or start sequence.

A stop command acts at once. It clears the CPU control word and the peripheral reset word, and it turns off the host interrupt enable, which masks the interrupt outputs. Only the instance strapped as controller zero (`isPrimary`) obeys a stop.

Top module: `board_rst_seq`

## Requirements
- R1: After power-on reset, the bridge soft-reset, reload, cold-enable, warm-enable, `busy` and `done` outputs are all 0, `periphCtl` is all ones and `hostIrqEn` is 1.
- R2: An accepted reset command sets `bridgeSoftRst` on the acceptance edge. The line stays high until the first tick after that edge (PULSE_TICKS=1), then stays low for one gap of GAP_TICKS=1 ticks.
- R3: After the first gap, `eepromReload` is high for PULSE_TICKS ticks and then low for GAP_TICKS ticks. It is never high while `bridgeSoftRst` is high.
- R4: The reset sequence ends on the edge of the last gap tick. On that edge the CPU word (`cpuWarmEn`,`cpuColdEn`) becomes 00, `done` pulses and `busy` falls.
- R5: An accepted start command sets the CPU word to cold=1, warm=0 and holds it for COLD_TICKS=2 ticks.
- R6: After the cold wait, the CPU word becomes cold=1, warm=1 and stays there. After WARM_TICKS=10 further ticks, `done` pulses and `busy` falls. Warm is never set without cold.
- R7: A stop command accepted while idle with `isPrimary`=1 clears the CPU word, sets `periphCtl` to 0 and clears `hostIrqEn`, all on the next edge. `irqOut` equals `irqReq` ANDed with `hostIrqEn`.
- R8: A stop command with `isPrimary`=0 changes no output.
- R9: While `busy` is high, reset, start and stop commands are ignored. `busy` rises only on the edge that accepts a reset or start command.
- R10: A tick in the acceptance cycle does not count toward a wait, and clock cycles without a tick do not advance a wait.
- R11: When several commands arrive together while idle, reset wins over start, and start wins over stop.
- R12: `done` is a single-cycle pulse. It is produced only at the end of a reset or start sequence, never for a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous power-on reset |
| tickStb | input | 1 | One-cycle time-base strobe |
| cmdReset | input | 1 | Request for the board reset sequence |
| cmdStart | input | 1 | Request for the CPU start sequence |
| cmdStop | input | 1 | Request to stop the CPU and mask interrupts |
| isPrimary | input | 1 | High on the instance that is controller zero |
| irqReq | input | IRQ_W | Raw interrupt requests |
| bridgeSoftRst | output | 1 | Bridge soft-reset line |
| eepromReload | output | 1 | Bridge configuration EEPROM reload line |
| cpuColdEn | output | 1 | CPU cold-reset enable |
| cpuWarmEn | output | 1 | CPU warm-reset enable |
| periphCtl | output | PERIPH_W | Peripheral/DSP reset word, all ones while running |
| hostIrqEn | output | 1 | Host interrupt enable |
| irqOut | output | IRQ_W | Masked interrupt outputs |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse at the end of a sequence |

## Verification
The bench places ticks in the acceptance cycle and leaves gaps of several cycles between ticks. A design that counted from the command cycle, or counted cycles instead of ticks, would end its pulses one step early or drift off the table. It sends start and stop commands in the middle of a sequence; a design that accepted them would switch the CPU word or clear the peripheral word too soon. It also sends commands in pairs and stops from a non-primary instance, where the wrong priority or a missing instance check shows up as a changed CPU word or interrupt enable.

// File: rtl/board_rst_seq_pkg.sv
package board_rst_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_SOFT, S_GAP1, S_RELOAD, S_GAP2, S_COLD, S_WARM
  } seqState_e;

  typedef enum logic [1:0] {
    W_PULSE, W_GAP, W_COLD, W_WARM
  } waitSel_e;

  typedef struct packed {
    logic       load;
    waitSel_e   waitSel;
    logic       setSoft;
    logic       clrSoft;
    logic       setReload;
    logic       clrReload;
    logic       cpuWr;
    logic [1:0] cpuVal;   // {warm, cold}
    logic       stopWr;
    logic       finish;
  } seqCtrl_t;

endpackage

// File: rtl/board_rst_seq_ctrl.sv
module board_rst_seq_ctrl
  import board_rst_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     cmdReset,
  input  logic     cmdStart,
  input  logic     cmdStop,
  input  logic     isPrimary,
  input  logic     waitOver,
  output seqCtrl_t ctrl,
  output logic     busy
);

  seqState_e state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNxt;
  end

  assign busy = (state != S_IDLE);

  always_comb begin
    stateNxt = state;
    ctrl     = '0;
    unique case (state)
      S_IDLE: begin
        if (cmdReset) begin
          stateNxt     = S_SOFT;
          ctrl.setSoft = 1'b1;
          ctrl.load    = 1'b1;
          ctrl.waitSel = W_PULSE;
        end else if (cmdStart) begin
          stateNxt     = S_COLD;
          ctrl.cpuWr   = 1'b1;
          ctrl.cpuVal  = 2'b01;
          ctrl.load    = 1'b1;
          ctrl.waitSel = W_COLD;
        end else if (cmdStop && isPrimary) begin
          ctrl.stopWr  = 1'b1;
        end
      end
      S_SOFT: if (waitOver) begin
        stateNxt     = S_GAP1;
        ctrl.clrSoft = 1'b1;
        ctrl.load    = 1'b1;
        ctrl.waitSel = W_GAP;
      end
      S_GAP1: if (waitOver) begin
        stateNxt       = S_RELOAD;
        ctrl.setReload = 1'b1;
        ctrl.load      = 1'b1;
        ctrl.waitSel   = W_PULSE;
      end
      S_RELOAD: if (waitOver) begin
        stateNxt       = S_GAP2;
        ctrl.clrReload = 1'b1;
        ctrl.load      = 1'b1;
        ctrl.waitSel   = W_GAP;
      end
      S_GAP2: if (waitOver) begin
        stateNxt    = S_IDLE;
        ctrl.cpuWr  = 1'b1;
        ctrl.cpuVal = 2'b00;
        ctrl.finish = 1'b1;
      end
      S_COLD: if (waitOver) begin
        stateNxt     = S_WARM;
        ctrl.cpuWr   = 1'b1;
        ctrl.cpuVal  = 2'b11;
        ctrl.load    = 1'b1;
        ctrl.waitSel = W_WARM;
      end
      S_WARM: if (waitOver) begin
        stateNxt    = S_IDLE;
        ctrl.finish = 1'b1;
      end
      default: stateNxt = S_IDLE;
    endcase
  end

endmodule

// File: rtl/board_rst_seq_dp.sv
module board_rst_seq_dp
  import board_rst_seq_pkg::*;
#(
  parameter int unsigned PULSE_TICKS = 1,
  parameter int unsigned GAP_TICKS   = 1,
  parameter int unsigned COLD_TICKS  = 2,
  parameter int unsigned WARM_TICKS  = 10,
  parameter int unsigned PERIPH_W    = 4,
  parameter int unsigned IRQ_W       = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tickStb,
  input  seqCtrl_t            ctrl,
  input  logic [IRQ_W-1:0]    irqReq,
  output logic                waitOver,
  output logic                bridgeSoftRst,
  output logic                eepromReload,
  output logic                cpuColdEn,
  output logic                cpuWarmEn,
  output logic [PERIPH_W-1:0] periphCtl,
  output logic                hostIrqEn,
  output logic [IRQ_W-1:0]    irqOut,
  output logic                done
);

  localparam int unsigned MAX_A = (PULSE_TICKS > GAP_TICKS) ? PULSE_TICKS : GAP_TICKS;
  localparam int unsigned MAX_B = (COLD_TICKS > WARM_TICKS) ? COLD_TICKS : WARM_TICKS;
  localparam int unsigned MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned CNT_W = $clog2(MAX_T + 1);

  logic [CNT_W-1:0] cnt, loadVal;

  always_comb begin
    unique case (ctrl.waitSel)
      W_PULSE: loadVal = CNT_W'(PULSE_TICKS);
      W_GAP:   loadVal = CNT_W'(GAP_TICKS);
      W_COLD:  loadVal = CNT_W'(COLD_TICKS);
      default: loadVal = CNT_W'(WARM_TICKS);
    endcase
  end

  assign waitOver = tickStb && (cnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          cnt <= '0;
    else if (ctrl.load)                 cnt <= loadVal;
    else if (tickStb && (cnt != '0))    cnt <= cnt - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bridgeSoftRst <= 1'b0;
      eepromReload  <= 1'b0;
      cpuColdEn     <= 1'b0;
      cpuWarmEn     <= 1'b0;
      periphCtl     <= '1;
      hostIrqEn     <= 1'b1;
      done          <= 1'b0;
    end else begin
      if (ctrl.setSoft)   bridgeSoftRst <= 1'b1;
      if (ctrl.clrSoft)   bridgeSoftRst <= 1'b0;
      if (ctrl.setReload) eepromReload  <= 1'b1;
      if (ctrl.clrReload) eepromReload  <= 1'b0;
      if (ctrl.cpuWr) begin
        cpuColdEn <= ctrl.cpuVal[0];
        cpuWarmEn <= ctrl.cpuVal[1];
      end
      if (ctrl.stopWr) begin
        cpuColdEn <= 1'b0;
        cpuWarmEn <= 1'b0;
        periphCtl <= '0;
        hostIrqEn <= 1'b0;
      end
      done <= ctrl.finish;
    end
  end

  assign irqOut = irqReq & {IRQ_W{hostIrqEn}};

endmodule

// File: rtl/board_rst_seq.sv
module board_rst_seq
  import board_rst_seq_pkg::*;
#(
  parameter int unsigned PULSE_TICKS = 1,
  parameter int unsigned GAP_TICKS   = 1,
  parameter int unsigned COLD_TICKS  = 2,
  parameter int unsigned WARM_TICKS  = 10,
  parameter int unsigned PERIPH_W    = 4,
  parameter int unsigned IRQ_W       = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tickStb,
  input  logic                cmdReset,
  input  logic                cmdStart,
  input  logic                cmdStop,
  input  logic                isPrimary,
  input  logic [IRQ_W-1:0]    irqReq,
  output logic                bridgeSoftRst,
  output logic                eepromReload,
  output logic                cpuColdEn,
  output logic                cpuWarmEn,
  output logic [PERIPH_W-1:0] periphCtl,
  output logic                hostIrqEn,
  output logic [IRQ_W-1:0]    irqOut,
  output logic                busy,
  output logic                done
);

  seqCtrl_t ctrl;
  logic     waitOver;

  board_rst_seq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdReset  (cmdReset),
    .cmdStart  (cmdStart),
    .cmdStop   (cmdStop),
    .isPrimary (isPrimary),
    .waitOver  (waitOver),
    .ctrl      (ctrl),
    .busy      (busy)
  );

  board_rst_seq_dp #(
    .PULSE_TICKS (PULSE_TICKS),
    .GAP_TICKS   (GAP_TICKS),
    .COLD_TICKS  (COLD_TICKS),
    .WARM_TICKS  (WARM_TICKS),
    .PERIPH_W    (PERIPH_W),
    .IRQ_W       (IRQ_W)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .tickStb       (tickStb),
    .ctrl          (ctrl),
    .irqReq        (irqReq),
    .waitOver      (waitOver),
    .bridgeSoftRst (bridgeSoftRst),
    .eepromReload  (eepromReload),
    .cpuColdEn     (cpuColdEn),
    .cpuWarmEn     (cpuWarmEn),
    .periphCtl     (periphCtl),
    .hostIrqEn     (hostIrqEn),
    .irqOut        (irqOut),
    .done          (done)
  );

endmodule

// File: rtl/board_rst_seq_chk.sv
module board_rst_seq_chk #(
  parameter int unsigned PERIPH_W = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                cmdReset,
  input logic                cmdStart,
  input logic                cmdStop,
  input logic                isPrimary,
  input logic                bridgeSoftRst,
  input logic                eepromReload,
  input logic                cpuColdEn,
  input logic                cpuWarmEn,
  input logic [PERIPH_W-1:0] periphCtl,
  input logic                hostIrqEn,
  input logic                busy,
  input logic                done
);

  AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(bridgeSoftRst && eepromReload)); // R3

  AST_BRIDGE_IN_SEQ: assert property (@(posedge clk) disable iff (!rstN)
    (bridgeSoftRst || eepromReload) |-> busy); // R2

  AST_WARM_NEEDS_COLD: assert property (@(posedge clk) disable iff (!rstN)
    cpuWarmEn |-> cpuColdEn); // R6

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R12

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R4

  AST_BUSY_FROM_CMD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(cmdReset || cmdStart)); // R9

  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStop && isPrimary && !busy && !cmdReset && !cmdStart)
      |=> (!hostIrqEn && !cpuColdEn && !cpuWarmEn && (periphCtl == '0) && !done)); // R7

  AST_STOP_SECONDARY: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStop && !isPrimary) |=> $stable(hostIrqEn) && $stable(periphCtl)); // R8

endmodule

bind board_rst_seq board_rst_seq_chk #(.PERIPH_W(PERIPH_W)) u_chk (.*);

// File: tb/board_rst_seq_tb.sv
module board_rst_seq_tb;

  localparam int PW = 4;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickStb = 1'b0, cmdReset = 1'b0, cmdStart = 1'b0, cmdStop = 1'b0;
  logic isPrimary = 1'b1;
  logic [IW-1:0] irqReq = '0;
  logic bridgeSoftRst, eepromReload, cpuColdEn, cpuWarmEn, hostIrqEn, busy, done;
  logic [PW-1:0] periphCtl;
  logic [IW-1:0] irqOut;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  board_rst_seq u_dut (.*);

  // {reset, start, stop, tick} -> {soft, reload, cold, warm, busy, done}
  localparam int NV = 23;
  localparam logic [9:0] VEC [NV] = '{
    10'b1001_100010, // reset accepted, tick in same cycle ignored
    10'b0000_100010, // no tick: still pulsing
    10'b0001_000010, // soft pulse over, gap
    10'b0001_010010, // reload pulse
    10'b0100_010010, // start while busy ignored
    10'b0001_000010, // gap after reload
    10'b0000_000010,
    10'b0001_000001, // end: cpu word 00, done
    10'b0000_000000,
    10'b0101_001010, // start accepted, tick ignored
    10'b0001_001010,
    10'b0001_001110, // warm joins
    10'b0001_001110, 10'b0001_001110, 10'b0001_001110,
    10'b0001_001110, 10'b0001_001110, 10'b0001_001110,
    10'b0001_001110, 10'b0001_001110, 10'b0001_001110,
    10'b0001_001101, // tenth tick: done
    10'b0000_001100
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cycle(input logic r, input logic s, input logic p, input logic t);
    cmdReset = r; cmdStart = s; cmdStop = p; tickStb = t;
    @(negedge clk);
    cmdReset = 1'b0; cmdStart = 1'b0; cmdStop = 1'b0; tickStb = 1'b0;
  endtask

  function automatic logic [5:0] outs();
    return {bridgeSoftRst, eepromReload, cpuColdEn, cpuWarmEn, busy, done};
  endfunction

  initial begin
    #2_000_000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 power-on state
    check("R1 outputs", {26'd0, outs()}, 32'd0);
    check("R1 periphCtl", periphCtl, 32'hF);
    check("R1 hostIrqEn", hostIrqEn, 1);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      cycle(VEC[i][9], VEC[i][8], VEC[i][7], VEC[i][6]);
      if (i < 10)
        check($sformatf("R2 R3 R4 R9 R10 reset step %0d", i), outs(), VEC[i][5:0]);
      else
        check($sformatf("R5 R6 R10 start step %0d", i), outs(), VEC[i][5:0]);
    end

    // R8 stop from non-primary instance has no effect
    isPrimary = 1'b0;
    irqReq = 4'hA;
    cycle(0, 0, 1, 0);
    check("R8 cpu word", {cpuWarmEn, cpuColdEn}, 2'b11);
    check("R8 periphCtl", periphCtl, 32'hF);
    check("R8 irqOut", irqOut, 32'hA);

    // R7 stop on primary, R12 no done
    isPrimary = 1'b1;
    cycle(0, 0, 1, 0);
    check("R7 cpu word", {cpuWarmEn, cpuColdEn}, 2'b00);
    check("R7 periphCtl", periphCtl, 32'h0);
    check("R7 hostIrqEn", hostIrqEn, 0);
    check("R7 irqOut", irqOut, 32'h0);
    check("R12 no done on stop", {busy, done}, 2'b00);

    // R11 reset beats start
    cycle(1, 1, 0, 0);
    check("R11 reset wins", outs(), 32'b100010);

    // R9 stop while busy ignored (fresh power-on first)
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    cycle(0, 1, 0, 0);
    cycle(0, 0, 1, 1);
    check("R9 stop during busy periph", periphCtl, 32'hF);
    check("R9 stop during busy cpu", {cpuWarmEn, cpuColdEn, busy}, 3'b011);
    cycle(1, 0, 0, 0);
    check("R9 reset during busy", bridgeSoftRst, 0);
    for (int k = 0; k < 11; k++) cycle(0, 0, 0, 1);
    check("R6 done after warm wait", {cpuWarmEn, cpuColdEn, busy, done}, 4'b1101);

    // R11 start beats stop
    cycle(1, 0, 0, 0);
    repeat (4) cycle(0, 0, 0, 1);
    check("R4 cpu word after reset seq", {cpuWarmEn, cpuColdEn, done}, 3'b001);
    cycle(0, 1, 1, 0);
    check("R11 start wins over stop", {cpuWarmEn, cpuColdEn, busy}, 3'b011);
    check("R11 periph kept", periphCtl, 32'hF);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule